// File: doc/BRIEF.md
# Peripheral Reset and Clock-Stop Handshake Controller

This block sits inside a register-mapped peripheral. It owns one configuration word and one status word behind a simple read/write port. The configuration word holds an auto-clearing software reset trigger, a two-bit idle policy, a hint that says whether the functional clock must keep running while idle, and an enable for automatic clock gating. The status word reports whether the internal reset has completed.

On a hardware reset, or when software writes 1 to the reset trigger, the block holds an active-low internal reset to the rest of the peripheral for a fixed number of cycles. The status bit reads 0 while that reset is held and 1 once it is over. A power manager requests a clock stop through a request input. The block answers with an acknowledge that follows the selected policy, the engine's busy input and any reset in progress. The block also drives a clock-gate enable that combines the gating enable, the activity inputs and the idle state.

Top module: `rst_idle_ctrl`

## Requirements
- R1: After the hardware reset input is released, the configuration word (address 0) reads 0x011, the status word (address 1) reads 0, the internal reset output is low and the clock-gate enable is low.
- R2: The internal reset output stays low for exactly RST_CYCLES (8) clock cycles after release of the hardware reset or after a write of 1 to configuration bit 1. Status bit 0 reads 0 during those cycles and 1 afterwards.
- R3: Configuration bit 1 reads 1 while a software-started reset sequence runs. It clears itself in the cycle that the sequence ends.
- R4: The configuration word keeps only bit 0 (clock-gating enable), bit 1 (reset trigger), bits 4:3 (idle policy) and bit 8 (keep-clock hint). All other bits read 0 and ignore writes. In the status word only bit 0 is ever 1, and writes to it have no effect. Addresses 2 and 3 read 0.
- R5: Idle policy 0 (forced) drives the acknowledge equal to the request in the same cycle, regardless of the busy input or a reset in progress.
- R6: Idle policy 1 (never) keeps the acknowledge low at all times.
- R7: Idle policy 2 (activity-based) raises the acknowledge one cycle after the request is high, the busy input is low and no internal reset is in progress. It keeps the acknowledge high while the request stays high and drops it in the same cycle the request falls.
- R8: Idle policy 3 behaves exactly as policy 2.
- R9: The clock-gate enable is high when configuration bit 0 is 0, when the bus-activity or busy input is high, or when the acknowledge is high with configuration bit 8 set. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (0 = configuration, 1 = status) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr, combinational |
| busy_i | input | 1 | Engine busy indication |
| bus_active_i | input | 1 | Register interface activity indication |
| idle_req_i | input | 1 | Clock-stop request from the power manager |
| idle_ack_o | output | 1 | Clock-stop acknowledge |
| core_rst_n_o | output | 1 | Active-low internal reset to the peripheral |
| clk_en_o | output | 1 | Functional clock-gate enable |

## Verification
The reset-length check assumes that software does not write the reset trigger while a sequence is already running. Such a write is ignored, so every low period of the internal reset is exactly RST_CYCLES long. The stimulus only starts a software reset after the status bit has returned to 1. The acknowledge-rise check assumes that the request, busy and activity inputs change only between clock edges. The stimulus drives every input on the falling edge and changes the idle policy only through full configuration writes.

// File: rtl/ric_pkg.sv
// ric_pkg: shared field positions and types for the reset/idle controller.
// Assumes a register word of at least 9 bits.
package ric_pkg;

    // Field positions inside the configuration word
    localparam int BIT_AUTOGATE = 0;
    localparam int BIT_SRST     = 1;
    localparam int BIT_MODE_LO  = 3;
    localparam int BIT_MODE_HI  = 4;
    localparam int BIT_KEEPCLK  = 8;

    // Clock-stop answer policy
    typedef enum logic [1:0] {
        IDLE_FORCE = 2'd0,
        IDLE_NEVER = 2'd1,
        IDLE_SMART = 2'd2,
        IDLE_RSVD  = 2'd3
    } idle_mode_e;

    // Decoded configuration state
    typedef struct packed {
        logic       keep_clk;
        idle_mode_e mode;
        logic       soft_rst;
        logic       auto_gate;
    } cfg_t;

endpackage

// File: rtl/ric_cfg_reg.sv
// ric_cfg_reg: configuration word storage and read-back formatting.
// Assumes wr_en is already qualified by the address decode. A reset
// trigger written while a sequence runs is dropped.
module ric_cfg_reg
    import ric_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              seq_active,
    input  logic              seq_end,
    output cfg_t              cfg,
    output logic              start,
    output logic [DATA_W-1:0] rdata
);

    // Bits that carry no field are discarded
    logic unused_wdata;
    assign unused_wdata = ^{wdata[DATA_W-1:BIT_KEEPCLK+1],
                            wdata[BIT_KEEPCLK-1:BIT_MODE_HI+1],
                            wdata[BIT_MODE_LO-1:BIT_SRST+1]};

    // A new sequence starts only when none is running
    assign start = wr_en && wdata[BIT_SRST] && !seq_active;

    // Field storage with hardware reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.auto_gate <= 1'b1;
            cfg.mode      <= IDLE_SMART;
            cfg.keep_clk  <= 1'b0;
        end else if (wr_en) begin
            cfg.auto_gate <= wdata[BIT_AUTOGATE];
            cfg.mode      <= idle_mode_e'(wdata[BIT_MODE_HI:BIT_MODE_LO]);
            cfg.keep_clk  <= wdata[BIT_KEEPCLK];
        end
    end

    // Self-clearing reset trigger
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg.soft_rst <= 1'b0;
        else if (start)   cfg.soft_rst <= 1'b1;
        else if (seq_end) cfg.soft_rst <= 1'b0;
    end

    // Read-back with all unused bits at zero
    always_comb begin
        rdata                           = '0;
        rdata[BIT_AUTOGATE]             = cfg.auto_gate;
        rdata[BIT_SRST]                 = cfg.soft_rst;
        rdata[BIT_MODE_HI:BIT_MODE_LO]  = cfg.mode;
        rdata[BIT_KEEPCLK]              = cfg.keep_clk;
    end

endmodule

// File: rtl/ric_reset_seq.sv
// ric_reset_seq: holds the internal reset for RST_CYCLES clocks.
// Runs once out of hardware reset and again on each start pulse.
// Assumes RST_CYCLES >= 2 and that start only arrives while idle.
module ric_reset_seq #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic seq_end
);

    localparam int             CNT_W = $clog2(RST_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign seq_end = active && (cnt == LAST);

    // Cycle counter for the reset hold window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (seq_end) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            cnt    <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ric_idle_hs.sv
// ric_idle_hs: answers the clock-stop request according to the policy.
// The activity-based answer is latched one cycle after its conditions
// hold and is released combinationally when the request falls.
module ric_idle_hs
    import ric_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  idle_mode_e mode,
    input  logic       req,
    input  logic       busy,
    input  logic       rst_active,
    output logic       ack
);

    logic smart;
    logic granted_q;

    // The reserved code falls back to the activity-based policy
    assign smart = (mode == IDLE_SMART) || (mode == IDLE_RSVD);

    // Activity-based grant, held until the request drops
    always_ff @(posedge clk) begin
        if (!rst_n) granted_q <= 1'b0;
        else        granted_q <= req && smart && (granted_q || (!busy && !rst_active));
    end

    // Final acknowledge per policy
    always_comb begin
        unique case (mode)
            IDLE_FORCE: ack = req;
            IDLE_NEVER: ack = 1'b0;
            default:    ack = req && granted_q;
        endcase
    end

endmodule

// File: rtl/rst_idle_ctrl.sv
// rst_idle_ctrl: software reset and clock-stop handshake for a
// peripheral. Word 0 is configuration, word 1 is status, other words
// read zero. Read data is combinational on the address.
module rst_idle_ctrl
    import ric_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy_i,
    input  logic              bus_active_i,
    input  logic              idle_req_i,
    output logic              idle_ack_o,
    output logic              core_rst_n_o,
    output logic              clk_en_o
);

    localparam logic [ADDR_W-1:0] CFG_ADDR  = '0;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

    cfg_t              cfg_q;
    logic              cfg_wr;
    logic              seq_start;
    logic              seq_active;
    logic              seq_end;
    logic              ack;
    logic [DATA_W-1:0] cfg_rdata;

    assign cfg_wr = reg_wr_en && (reg_addr == CFG_ADDR);

    ric_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .wdata      (reg_wdata),
        .seq_active (seq_active),
        .seq_end    (seq_end),
        .cfg        (cfg_q),
        .start      (seq_start),
        .rdata      (cfg_rdata)
    );

    ric_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (seq_start),
        .active  (seq_active),
        .seq_end (seq_end)
    );

    ric_idle_hs u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cfg_q.mode),
        .req        (idle_req_i),
        .busy       (busy_i),
        .rst_active (seq_active),
        .ack        (ack)
    );

    // Register read multiplexer
    always_comb begin
        if (reg_addr == CFG_ADDR)       reg_rdata = cfg_rdata;
        else if (reg_addr == STAT_ADDR) reg_rdata = {{(DATA_W-1){1'b0}}, !seq_active};
        else                            reg_rdata = '0;
    end

    assign idle_ack_o   = ack;
    assign core_rst_n_o = !seq_active;

    // Clock request: gating off, activity, or idle with keep-clock hint
    assign clk_en_o = !cfg_q.auto_gate || bus_active_i || busy_i ||
                      (ack && cfg_q.keep_clk);

endmodule

// File: rtl/ric_checker.sv
// ric_checker: temporal properties of rst_idle_ctrl, bound to the top.
// Assumes inputs change only between clock edges.
module ric_checker #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int RST_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              busy_i,
    input logic              idle_req_i,
    input logic              idle_ack_o,
    input logic              core_rst_n_o,
    input logic [1:0]        cfg_mode
);

    localparam int                CW        = $clog2(RST_CYCLES + 2);
    localparam logic [DATA_W-1:0] CFG_MASK  = DATA_W'(32'h11B);

    logic [CW-1:0] low_cnt;

    // Counts consecutive cycles with the internal reset asserted
    always_ff @(posedge clk) begin
        if (!rst_n)             low_cnt <= '0;
        else if (!core_rst_n_o) low_cnt <= low_cnt + 1'b1;
        else                    low_cnt <= '0;
    end

    assert_reset_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n_o) |-> (low_cnt == CW'(RST_CYCLES)));

    assert_never_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1) |-> !idle_ack_o);

    assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req_i |-> !idle_ack_o);

    assert_smart_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1] && idle_ack_o && !$past(idle_ack_o))
        |-> $past(idle_req_i && !busy_i && core_rst_n_o));

    // Read-back must never expose unused bits
    always_comb begin
        if (rst_n && reg_addr == ADDR_W'(1))
            assert_status_rsvd_R4: assert (reg_rdata[DATA_W-1:1] == '0);
        if (rst_n && reg_addr == '0)
            assert_cfg_rsvd_R4: assert ((reg_rdata & ~CFG_MASK) == '0);
    end

endmodule

bind rst_idle_ctrl ric_checker #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .RST_CYCLES (RST_CYCLES)
) u_ric_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .busy_i       (busy_i),
    .idle_req_i   (idle_req_i),
    .idle_ack_o   (idle_ack_o),
    .core_rst_n_o (core_rst_n_o),
    .cfg_mode     (cfg_q.mode)
);

// File: tb/rst_idle_ctrl_bench.sv
// Scoreboard bench: the driver queues expected values, the monitor
// compares them against the ports two time units after each falling edge.
module rst_idle_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    typedef enum {SIG_RDATA, SIG_ACK, SIG_CLKEN, SIG_CORERST} sig_e;
    typedef struct {
        sig_e        sig;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy_i = 1'b0;
    logic        bus_active_i = 1'b0;
    logic        idle_req_i = 1'b0;
    logic        idle_ack_o;
    logic        core_rst_n_o;
    logic        clk_en_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_idle_ctrl u_rst_idle_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .busy_i       (busy_i),
        .bus_active_i (bus_active_i),
        .idle_req_i   (idle_req_i),
        .idle_ack_o   (idle_ack_o),
        .core_rst_n_o (core_rst_n_o),
        .clk_en_o     (clk_en_o)
    );

    task automatic expect_sig(input sig_e s, input logic [31:0] v, input string tag);
        item_t it;
        it.sig = s;
        it.exp = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [31:0] v, input string tag);
        reg_addr = a;
        expect_sig(SIG_RDATA, v, tag);
    endtask

    // Monitor: pops and compares queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                case (it.sig)
                    SIG_RDATA:   act = reg_rdata;
                    SIG_ACK:     act = {31'b0, idle_ack_o};
                    SIG_CLKEN:   act = {31'b0, clk_en_o};
                    default:     act = {31'b0, core_rst_n_o};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_expect(2'd0, 32'h11, "R1 cfg reset value");
        expect_sig(SIG_CORERST, 0, "R1 internal reset low");
        expect_sig(SIG_CLKEN, 0, "R1 clock enable low");
        expect_sig(SIG_ACK, 0, "R1 ack low");
        tick(1);
        rd_expect(2'd1, 32'h0, "R1 status zero");
        tick(6);
        rd_expect(2'd1, 32'h0, "R2 status still 0 at last reset cycle");
        tick(1);
        rd_expect(2'd1, 32'h1, "R2 status done after 8 cycles");
        expect_sig(SIG_CORERST, 1, "R2 internal reset released");

        // R4 field layout and ignored writes
        tick(1);
        wr(2'd0, 32'hFFFF_FFFD);
        rd_expect(2'd0, 32'h119, "R4 cfg reserved bits read 0");
        tick(1);
        wr(2'd1, 32'hFFFF_FFFF);
        rd_expect(2'd1, 32'h1, "R4 status write ignored");
        expect_sig(SIG_CORERST, 1, "R4 status write starts no reset");
        tick(1);
        rd_expect(2'd2, 32'h0, "R4 address 2 reads 0");
        tick(1);
        rd_expect(2'd3, 32'h0, "R4 address 3 reads 0");

        // R8 reserved policy (cfg now mode 3, gating on, keep set)
        tick(1);
        idle_req_i = 1'b1;
        expect_sig(SIG_ACK, 0, "R8 no ack in request cycle");
        tick(1);
        expect_sig(SIG_ACK, 1, "R8 ack one cycle later");
        expect_sig(SIG_CLKEN, 1, "R9 keep-clock while idle");
        tick(1);
        busy_i = 1'b1;
        expect_sig(SIG_ACK, 1, "R8 ack held when busy rises");
        tick(1);
        idle_req_i = 1'b0;
        expect_sig(SIG_ACK, 0, "R8 ack drops with request");
        tick(1);
        busy_i = 1'b0;

        // R7 activity-based policy
        wr(2'd0, 32'h11);
        busy_i = 1'b1;
        idle_req_i = 1'b1;
        tick(2);
        expect_sig(SIG_ACK, 0, "R7 no ack while busy");
        tick(1);
        busy_i = 1'b0;
        expect_sig(SIG_ACK, 0, "R7 ack waits one cycle");
        tick(1);
        expect_sig(SIG_ACK, 1, "R7 ack after busy falls");
        expect_sig(SIG_CLKEN, 0, "R9 gated while idle without keep");
        tick(1);
        busy_i = 1'b1;
        expect_sig(SIG_ACK, 1, "R7 ack held");
        expect_sig(SIG_CLKEN, 1, "R9 busy enables clock");
        tick(1);
        idle_req_i = 1'b0;
        expect_sig(SIG_ACK, 0, "R7 ack drops with request");
        tick(1);
        busy_i = 1'b0;

        // R3 and R7: soft reset blocks the activity-based ack
        wr(2'd0, 32'h13);
        idle_req_i = 1'b1;
        rd_expect(2'd0, 32'h13, "R3 trigger reads 1 while running");
        expect_sig(SIG_CORERST, 0, "R2 soft reset asserted");
        expect_sig(SIG_ACK, 0, "R7 no ack during reset");
        tick(7);
        expect_sig(SIG_CORERST, 0, "R2 soft reset held 8th cycle");
        expect_sig(SIG_ACK, 0, "R7 still no ack at reset end");
        tick(1);
        rd_expect(2'd0, 32'h11, "R3 trigger cleared at end");
        expect_sig(SIG_CORERST, 1, "R2 soft reset released");
        expect_sig(SIG_ACK, 0, "R7 ack not yet after reset");
        tick(1);
        expect_sig(SIG_ACK, 1, "R7 ack once reset is over");
        tick(1);
        idle_req_i = 1'b0;

        // R5 forced policy
        wr(2'd0, 32'h01);
        busy_i = 1'b1;
        idle_req_i = 1'b1;
        expect_sig(SIG_ACK, 1, "R5 immediate ack despite busy");
        tick(1);
        idle_req_i = 1'b0;
        expect_sig(SIG_ACK, 0, "R5 ack follows request low");
        tick(1);
        busy_i = 1'b0;
        wr(2'd0, 32'h03);
        idle_req_i = 1'b1;
        expect_sig(SIG_ACK, 1, "R5 ack during reset");
        expect_sig(SIG_CORERST, 0, "R5 reset running");
        tick(8);
        idle_req_i = 1'b0;
        rd_expect(2'd1, 32'h1, "R2 second soft reset done");

        // R6 never policy
        tick(1);
        wr(2'd0, 32'h09);
        idle_req_i = 1'b1;
        tick(3);
        expect_sig(SIG_ACK, 0, "R6 never acknowledges");
        tick(1);
        idle_req_i = 1'b0;

        // R9 clock-gate enable
        wr(2'd0, 32'h00);
        expect_sig(SIG_CLKEN, 1, "R9 free-running when gating off");
        tick(1);
        wr(2'd0, 32'h01);
        expect_sig(SIG_CLKEN, 0, "R9 gated when quiet");
        tick(1);
        bus_active_i = 1'b1;
        expect_sig(SIG_CLKEN, 1, "R9 bus activity enables");
        tick(1);
        bus_active_i = 1'b0;
        busy_i = 1'b1;
        expect_sig(SIG_CLKEN, 1, "R9 busy enables");
        tick(1);
        busy_i = 1'b0;
        idle_req_i = 1'b1;
        expect_sig(SIG_CLKEN, 0, "R9 idle acked without keep");
        tick(1);
        wr(2'd0, 32'h101);
        expect_sig(SIG_CLKEN, 1, "R9 idle acked with keep");
        tick(1);
        idle_req_i = 1'b0;
        expect_sig(SIG_CLKEN, 0, "R9 keep has no effect when not idle");

        tick(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule